// File: doc/BRIEF.md
# Guarded Control Register with Dual Write Sources

This block holds one control/status value of configurable width. Two agents may update it. The first is the instruction-driven functional unit, which executes register read/modify/write operations. The second is a hardware update port, which other core logic uses to post status changes. A fixed protection mask marks bits that the functional unit may never modify. Those bits change only through the hardware port.

When both sources write in the same cycle, the writable bits are resolved by a priority parameter. By default the functional unit wins. With the parameter cleared, the hardware port wins. The protected bits always follow the hardware port when it writes.

The block offers three views of the value:
- A functional-unit read port, which returns the value as it was before any write in the same cycle.
- A registered observation port, which reports the stored value. It also reports two flags showing whether the functional unit read or wrote the register in the previous cycle.
- A combinational peek port, which shows the functional unit's raw write data in the cycle it is presented, before any masking.

Top module: `guarded_ctrl_reg`

## Requirements
- R1: During and right after a synchronous active-low reset, the observation port shows the parameter RESET_VAL and both access flags read 0.
- R2: A functional-unit write with no concurrent hardware write leaves every bit set in RO_MASK at its previous value.
- R3: On a cycle with a hardware write, the bits set in RO_MASK take the hardware write data from the next cycle on. This holds whether or not the functional unit also writes, and under either priority.
- R4: With FU_FIRST=1, a functional-unit write sets the bits clear in RO_MASK to its data, even when a hardware write happens in the same cycle.
- R5: With FU_FIRST=0, a concurrent hardware write sets every bit to the hardware data, and the functional-unit data is discarded. Example: functional unit 0x0FFF with hardware 0xAAAA stores 0xAAAA.
- R6: A hardware write alone loads all bits, protected or not, from its data.
- R7: The functional-unit read data equals the stored value from before any write of that same cycle.
- R8: After each clock, the observation port shows the updated value. Its read flag equals the functional-unit read request of the previous cycle, and its written flag equals the functional-unit write request of the previous cycle. This holds even when the write lost priority.
- R9: The peek port shows the raw functional-unit write data in the same cycle while a functional-unit write is requested, and the stored value otherwise. Example: RESET_VAL 0xAB, RO_MASK 0xF, a write of 0xFFFF peeks as 0xFFFF and stores 0xFFFB.
- R10: In a cycle with neither write, the stored value holds. If the functional unit also does not read in that cycle, both access flags read 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fu_wr_en | input | 1 | Functional-unit write request |
| fu_wr_data | input | WIDTH | Functional-unit write data |
| fu_rd_en | input | 1 | Functional-unit read request |
| fu_rd_data | output | WIDTH | Value before this cycle's write |
| hw_wr_en | input | 1 | Hardware update request |
| hw_wr_data | input | WIDTH | Hardware update data |
| obs_data | output | WIDTH | Stored value |
| obs_rd_flag | output | 1 | Functional unit read in the previous cycle |
| obs_wr_flag | output | 1 | Functional unit wrote in the previous cycle |
| peek_data | output | WIDTH | Raw pending functional-unit write data, else the stored value |

## Verification
The embedded properties check several rules on every clock cycle:
- Protected bits are unchanged after a lone functional-unit write.
- Protected bits follow the hardware data whenever the hardware port writes.
- The winning source sets the writable bits, under whichever priority was elaborated.
- The value holds when nothing writes.
- The access flags track the previous cycle's requests.

Only the bench scenarios can show two things. The first is the same-cycle view ordering: the read data is pre-write while the peek data is raw pre-mask. The second is the concrete example values. Because the bench runs one instance per priority setting against its reference model, it also shows that the two elaborations differ only when both sources collide.

// File: rtl/guarded_ctrl_reg_pkg.sv
// Shared types for the guarded control register.
// Assumes: nothing beyond IEEE 1800-2017 packed types.
package guarded_ctrl_reg_pkg;

    // Source chosen for one group of bits in a cycle.
    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_FU   = 2'd1,
        SRC_HW   = 2'd2
    } src_sel_e;

    // Per-cycle functional-unit access record.
    typedef struct packed {
        logic rd;
        logic wr;
    } acc_flags_t;

endpackage

// File: rtl/gcr_merge.sv
// Write merge: picks, for protected and writable bit groups separately,
// which source defines the next value. The priority variant is chosen at
// elaboration. Purely combinational; assumes the caller registers 'nxt'.
module gcr_merge
    import guarded_ctrl_reg_pkg::*;
#(
    parameter int          WIDTH    = 32,
    parameter logic [WIDTH-1:0] RO_MASK = '0,
    parameter bit          FU_FIRST = 1'b1
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             fu_wr,
    input  logic [WIDTH-1:0] fu_data,
    input  logic             hw_wr,
    input  logic [WIDTH-1:0] hw_data,
    output logic [WIDTH-1:0] nxt,
    output logic             upd
);
    localparam logic [WIDTH-1:0] RW_MASK = ~RO_MASK;

    src_sel_e         rw_sel;
    src_sel_e         ro_sel;
    logic [WIDTH-1:0] rw_val;
    logic [WIDTH-1:0] ro_val;

    generate
        if (FU_FIRST) begin : g_fu_first
            // Writable bits: functional unit beats the hardware port.
            always_comb begin
                if (fu_wr)      rw_sel = SRC_FU;
                else if (hw_wr) rw_sel = SRC_HW;
                else            rw_sel = SRC_HOLD;
            end
        end else begin : g_hw_first
            // Writable bits: hardware port beats the functional unit.
            always_comb begin
                if (hw_wr)      rw_sel = SRC_HW;
                else if (fu_wr) rw_sel = SRC_FU;
                else            rw_sel = SRC_HOLD;
            end
        end
    endgenerate

    // Protected bits: only the hardware port may change them.
    always_comb begin
        ro_sel = hw_wr ? SRC_HW : SRC_HOLD;
    end

    // Resolve the selected source of the writable group into a value.
    always_comb begin
        case (rw_sel)
            SRC_FU:  rw_val = fu_data;
            SRC_HW:  rw_val = hw_data;
            default: rw_val = cur;
        endcase
    end

    // Resolve the selected source of the protected group into a value.
    always_comb begin
        case (ro_sel)
            SRC_HW:  ro_val = hw_data;
            default: ro_val = cur;
        endcase
    end

    // Combine both groups under the mask and flag any change request.
    always_comb begin
        nxt = (rw_val & RW_MASK) | (ro_val & RO_MASK);
        upd = fu_wr | hw_wr;
    end
endmodule

// File: rtl/gcr_store.sv
// Value storage: a loadable register with synchronous active-low reset.
// Assumes 'upd' is low whenever 'nxt' must not be taken.
module gcr_store #(
    parameter int               WIDTH     = 32,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [WIDTH-1:0] nxt,
    output logic [WIDTH-1:0] q
);
    // Load the merged value when an update is requested.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= RESET_VAL;
        else if (upd) q <= nxt;
    end

    // R10
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(q));
endmodule

// File: rtl/gcr_flags.sv
// Access flag register: records this cycle's functional-unit read and
// write requests for the observation port. Synchronous active-low reset.
module gcr_flags
    import guarded_ctrl_reg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fu_rd,
    input  logic       fu_wr,
    output acc_flags_t flags
);
    // Capture both requests each clock; clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= '{rd: fu_rd, wr: fu_wr};
    end

    // R10
    flags_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fu_rd && !fu_wr) |=> (flags == '0));
    // R8
    flags_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (flags.wr == $past(fu_wr) && flags.rd == $past(fu_rd)));
endmodule

// File: rtl/guarded_ctrl_reg.sv
// Guarded control register: one stored value with a masked functional-unit
// write port, a hardware update port, a pre-write read view, a registered
// observation view with access flags, and a raw peek view.
// Assumes a single clock and synchronous active-low reset; the mask and the
// priority are fixed at elaboration.
module guarded_ctrl_reg
    import guarded_ctrl_reg_pkg::*;
#(
    parameter int               WIDTH     = 32,
    parameter logic [WIDTH-1:0] RESET_VAL = 32'h0000_00AB,
    parameter logic [WIDTH-1:0] RO_MASK   = 32'h0000_000F,
    parameter bit               FU_FIRST  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fu_wr_en,
    input  logic [WIDTH-1:0] fu_wr_data,
    input  logic             fu_rd_en,
    output logic [WIDTH-1:0] fu_rd_data,
    input  logic             hw_wr_en,
    input  logic [WIDTH-1:0] hw_wr_data,
    output logic [WIDTH-1:0] obs_data,
    output logic             obs_rd_flag,
    output logic             obs_wr_flag,
    output logic [WIDTH-1:0] peek_data
);
    localparam logic [WIDTH-1:0] RW_MASK = ~RO_MASK;

    logic [WIDTH-1:0] cur_q;
    logic [WIDTH-1:0] nxt_d;
    logic             upd_d;
    acc_flags_t       flags_q;

    gcr_merge #(
        .WIDTH   (WIDTH),
        .RO_MASK (RO_MASK),
        .FU_FIRST(FU_FIRST)
    ) i_merge (
        .cur     (cur_q),
        .fu_wr   (fu_wr_en),
        .fu_data (fu_wr_data),
        .hw_wr   (hw_wr_en),
        .hw_data (hw_wr_data),
        .nxt     (nxt_d),
        .upd     (upd_d)
    );

    gcr_store #(
        .WIDTH    (WIDTH),
        .RESET_VAL(RESET_VAL)
    ) i_store (
        .clk  (clk),
        .rst_n(rst_n),
        .upd  (upd_d),
        .nxt  (nxt_d),
        .q    (cur_q)
    );

    gcr_flags i_flags (
        .clk  (clk),
        .rst_n(rst_n),
        .fu_rd(fu_rd_en),
        .fu_wr(fu_wr_en),
        .flags(flags_q)
    );

    // Drive the three read views from storage, flags and pending write.
    always_comb begin
        fu_rd_data  = cur_q;
        obs_data    = cur_q;
        obs_rd_flag = flags_q.rd;
        obs_wr_flag = flags_q.wr;
        peek_data   = fu_wr_en ? fu_wr_data : cur_q;
    end

    // R2
    ro_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fu_wr_en && !hw_wr_en) |=> ((obs_data & RO_MASK) == $past(obs_data & RO_MASK)));

    // R3
    ro_from_hw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_wr_en |=> ((obs_data & RO_MASK) == $past(hw_wr_data & RO_MASK)));

    generate
        if (FU_FIRST) begin : g_chk_fu
            // R4
            fu_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                fu_wr_en |=> ((obs_data & RW_MASK) == $past(fu_wr_data & RW_MASK)));
        end else begin : g_chk_hw
            // R5
            hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                hw_wr_en |=> (obs_data == $past(hw_wr_data)));
        end
    endgenerate
endmodule

// File: tb/test_guarded_ctrl_reg.sv
// Bench: two instances (functional-unit priority and hardware priority)
// driven by the same stimulus and compared with a behavioural model.
module test_guarded_ctrl_reg;
    localparam int          CLK_PERIOD = 10;
    localparam int          W          = 32;
    localparam logic [W-1:0] RST_V     = 32'h0000_00AB;
    localparam logic [W-1:0] RO_M      = 32'h0000_000F;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fu_wr_en = 1'b0, fu_rd_en = 1'b0, hw_wr_en = 1'b0;
    logic [W-1:0] fu_wr_data = '0, hw_wr_data = '0;

    logic [W-1:0] a_rd, a_obs, a_peek, b_rd, b_obs, b_peek;
    logic         a_rf, a_wf, b_rf, b_wf;

    int errors = 0;
    int checks = 0;

    // Reference state for each instance and the expected flags.
    logic [W-1:0] ma, mb;
    logic         m_rf, m_wf;

    always #(CLK_PERIOD/2) clk = ~clk;

    guarded_ctrl_reg #(.WIDTH(W), .RESET_VAL(RST_V), .RO_MASK(RO_M), .FU_FIRST(1'b1)) i_guarded_ctrl_reg (
        .clk(clk), .rst_n(rst_n), .fu_wr_en(fu_wr_en), .fu_wr_data(fu_wr_data),
        .fu_rd_en(fu_rd_en), .fu_rd_data(a_rd), .hw_wr_en(hw_wr_en), .hw_wr_data(hw_wr_data),
        .obs_data(a_obs), .obs_rd_flag(a_rf), .obs_wr_flag(a_wf), .peek_data(a_peek));

    guarded_ctrl_reg #(.WIDTH(W), .RESET_VAL(RST_V), .RO_MASK(RO_M), .FU_FIRST(1'b0)) i_guarded_ctrl_reg_hw (
        .clk(clk), .rst_n(rst_n), .fu_wr_en(fu_wr_en), .fu_wr_data(fu_wr_data),
        .fu_rd_en(fu_rd_en), .fu_rd_data(b_rd), .hw_wr_en(hw_wr_en), .hw_wr_data(hw_wr_data),
        .obs_data(b_obs), .obs_rd_flag(b_rf), .obs_wr_flag(b_wf), .peek_data(b_peek));

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Next value from the requirements: protected bits follow the hardware
    // port only; writable bits follow the winning source.
    function automatic logic [W-1:0] model_next(input logic [W-1:0] v, input bit fu_first);
        logic [W-1:0] r;
        r = v;
        if (hw_wr_en) r = hw_wr_data;
        if (fu_wr_en && (fu_first || !hw_wr_en))
            r = (fu_wr_data & ~RO_M) | (r & RO_M);
        return r;
    endfunction

    // Registered views compared with the model (called away from edges).
    task automatic check_regs(input string tag);
        check({tag, " obs fu-first"}, a_obs, ma);
        check({tag, " obs hw-first"}, b_obs, mb);
        check("R8 rd flag", {31'd0, a_rf}, {31'd0, m_rf});
        check("R8 wr flag", {31'd0, b_wf}, {31'd0, m_wf});
    endtask

    // One cycle: inputs set after a falling edge, same-cycle views checked,
    // model advanced at the rising edge, registered views checked after.
    task automatic cyc(input string tag, input logic fw, input logic [W-1:0] fd,
                       input logic hw, input logic [W-1:0] hd, input logic rd);
        fu_wr_en = fw; fu_wr_data = fd; hw_wr_en = hw; hw_wr_data = hd; fu_rd_en = rd;
        #1;
        check("R7 read pre-write", a_rd, ma);
        check("R7 read pre-write hw", b_rd, mb);
        check("R9 peek", a_peek, fw ? fd : ma);
        check("R9 peek hw", b_peek, fw ? fd : mb);
        @(posedge clk);
        ma = model_next(ma, 1'b1);
        mb = model_next(mb, 1'b0);
        m_rf = rd; m_wf = fw;
        @(negedge clk);
        check_regs(tag);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 5000);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        ma = RST_V; mb = RST_V; m_rf = 0; m_wf = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_regs("R1");
        rst_n = 1'b1;
        cyc("R10 idle", 0, '0, 0, '0, 0);
        check("R10 hold", a_obs, RST_V);
        // R9 example: raw write peeks, stored value masked
        cyc("R2 lone fu write", 1, 32'h0000_FFFF, 0, '0, 1);
        check("R2 example", a_obs, 32'h0000_FFFB);
        check("R8 written flag set", {31'd0, a_wf}, 32'd1);
        // R6: hardware write alone loads all bits
        cyc("R6 hw only", 0, '0, 1, 32'h1234_5675, 0);
        check("R6 all bits", a_obs, 32'h1234_5675);
        // R4/R5/R3: collision example
        cyc("R4 R5 collide", 1, 32'h0000_0FFF, 1, 32'h0000_AAAA, 0);
        check("R5 hw wins", b_obs, 32'h0000_AAAA);
        check("R4 fu wins", a_obs, 32'h0000_0FFA);
        check("R3 ro from hw", a_obs & RO_M, 32'h0000_000A);
        // R10: hold after collision, flags clear
        cyc("R10 idle2", 0, '0, 0, '0, 0);
        check("R10 flags zero", {30'd0, a_rf, a_wf}, 32'd0);
        // Read only
        cyc("R8 read only", 0, '0, 0, '0, 1);
        // Random traffic
        for (int i = 0; i < 300; i++) begin
            cyc("R8 random", ($urandom % 2) == 0, $urandom, ($urandom % 3) == 0, $urandom,
                ($urandom % 2) == 0);
        end
        // R1: reset again mid-run
        rst_n = 1'b0;
        @(posedge clk);
        ma = RST_V; mb = RST_V; m_rf = 0; m_wf = 0;
        @(negedge clk);
        check_regs("R1 rerun");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule